// File: doc/BRIEF.md
# LCD Quarter-Duty Waveform Generator

This block produces the drive-level codes for a multiplexed LCD panel. The panel has four common lines and a parameterised number of segment lines, driven at 1/4 duty and 1/2 bias. Every output is a 2-bit code for one of three levels: low, half or full. An analog stage outside the block turns each code into a voltage. Each segment holds a 4-bit pixel pattern, with one bit for each common. A divider derives the phase rate from the system clock. A frame has eight phases. During the first four phases each common is selected in turn with positive polarity. During the last four the same sequence repeats with the polarity inverted, so the panel never sees a DC bias.

The segment pattern input is sampled only when a frame starts, so a change made part-way through a frame never tears the image. While reset or the backup input is high, every output is held at the low code. When the block leaves reset or backup, the next frame starts from phase 0 and the pattern is sampled again.

Top module: `lcd_quad_drive`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every common and segment output carries the low code 2'b00.
- R2: The level codes are low = 2'b00, half = 2'b01 and full = 2'b10. The code 2'b11 never appears on any output.
- R3: In every drive phase exactly one common is selected and every other common carries the half code. Common k (bits [2k+1:2k] of `com_lvl_o`) is selected in phases k and k+4.
- R4: Each phase lasts DIV = CLK_HZ/(FRAME_HZ*8) clock cycles, so a frame of eight phases repeats at FRAME_HZ.
- R5: In phases 0 to 3 (positive half) the selected common carries the full code. In phases 4 to 7 (negative half) it carries the low code.
- R6: Segment s (bits [2s+1:2s] of `seg_lvl_o`) reads its pixel from bit 4s+k of `seg_pat_i`, where k is the selected common. A pixel that is on drives the rail opposite to the selected common. A pixel that is off drives the same rail. A segment never carries the half code while the block is driving.
- R7: `seg_pat_i` is sampled only at the start of a frame. A change made in the middle of a frame has no effect on the outputs until the next frame begins.
- R8: Backup forces every output to the low code from the cycle after it is sampled. When backup is released, driving restarts at phase 0 with a freshly sampled pattern, after one cycle that is still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| backup | input | 1 | Low-power hold: forces all outputs low |
| seg_pat_i | input | 4*NUM_SEG | Pixel pattern, bit 4s+k = segment s at common k |
| com_lvl_o | output | 8 | Level codes of the four commons, 2 bits each |
| seg_lvl_o | output | 2*NUM_SEG | Level codes of the segments, 2 bits each |

## Verification
The assertions check on every cycle that the rules of a single output hold. At most one common leaves the half level, no segment sits at half while driving, and code 2'b11 never appears. They also check that the divider stays in range, that the phase steps by one on each tick, and that the pattern register changes only at phase 0. They hold the outputs low in reset and in backup. Only the bench scenarios can show that the sequence is right from phase to phase. That covers the order of commons across a whole frame, the polarity flip between halves, and the exact phase length. It also covers the pattern staying frozen after a mid-frame change, and a clean restart at phase 0 after backup.

// File: rtl/lcd_quad_pkg.sv
package lcd_quad_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HALF = 2'b01,
    LVL_FULL = 2'b10
  } lvl_e;

  localparam int NUM_COM = 4;
  localparam int PHASES  = 2 * NUM_COM;
  localparam int PH_W    = $clog2(PHASES);
endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || hold)   cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // Divider count must never exceed its terminal value
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt) < DIV));
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_quad_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            tick,
  output logic [PH_W-1:0] phase,
  output logic            wrap
);
  assign wrap = tick && (phase == PH_W'(PHASES - 1));

  always_ff @(posedge clk) begin
    if (rst || hold) phase <= '0;
    else if (tick)   phase <= phase + 1'b1;
  end

  // Each tick advances exactly one phase (modulo a full frame)
  assert_phase_step_R4: assert property (@(posedge clk) disable iff (rst || hold)
    (tick && !hold) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_quad_pkg::*;
#(
  parameter int NUM_SEG = 4
) (
  input  logic [PH_W-1:0]          phase,
  input  logic [NUM_COM*NUM_SEG-1:0] pattern,
  output logic [2*NUM_COM-1:0]     com_lvl,
  output logic [2*NUM_SEG-1:0]     seg_lvl
);
  logic       positive;
  logic [1:0] sel;
  lvl_e       sel_rail;
  lvl_e       anti_rail;

  assign positive  = ~phase[PH_W-1];
  assign sel       = phase[1:0];
  assign sel_rail  = positive ? LVL_FULL : LVL_LOW;
  assign anti_rail = positive ? LVL_LOW  : LVL_FULL;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = (sel == 2'(c)) ? sel_rail : LVL_HALF;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] pix;
    assign pix = pattern[NUM_COM*s +: NUM_COM];
    assign seg_lvl[2*s +: 2] = pix[sel] ? anti_rail : sel_rail;
  end
endmodule

// File: rtl/lcd_quad_drive.sv
module lcd_quad_drive
  import lcd_quad_pkg::*;
#(
  parameter int NUM_SEG  = 16,
  parameter int CLK_HZ   = 200_000_000,
  parameter int FRAME_HZ = 75
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       backup,
  input  logic [NUM_COM*NUM_SEG-1:0] seg_pat_i,
  output logic [2*NUM_COM-1:0]       com_lvl_o,
  output logic [2*NUM_SEG-1:0]       seg_lvl_o
);
  localparam int DIV_RAW = CLK_HZ / (FRAME_HZ * PHASES);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic                       run;
  logic                       tick;
  logic                       wrap;
  logic                       load;
  logic [PH_W-1:0]            phase;
  logic [NUM_COM*NUM_SEG-1:0] shadow;
  logic [2*NUM_COM-1:0]       com_nx;
  logic [2*NUM_SEG-1:0]       seg_nx;

  assign load = (!run && !backup) || wrap;

  lcd_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .hold (backup || !run),
    .tick (tick)
  );

  lcd_phase_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .hold  (backup),
    .tick  (tick),
    .phase (phase),
    .wrap  (wrap)
  );

  lcd_level_enc #(.NUM_SEG(NUM_SEG)) u_enc (
    .phase   (phase),
    .pattern (shadow),
    .com_lvl (com_nx),
    .seg_lvl (seg_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) run <= 1'b0;
    else     run <= !backup;
  end

  always_ff @(posedge clk) begin
    if (rst)       shadow <= '0;
    else if (load) shadow <= seg_pat_i;
  end

  always_ff @(posedge clk) begin
    if (rst || backup || !run) begin
      com_lvl_o <= '0;
      seg_lvl_o <= '0;
    end else begin
      com_lvl_o <= com_nx;
      seg_lvl_o <= seg_nx;
    end
  end

  // ---------------- assertions ----------------
  logic [NUM_COM-1:0] com_active;
  logic [NUM_SEG-1:0] seg_half;
  logic               any_bad;

  always_comb begin
    any_bad = 1'b0;
    for (int c = 0; c < NUM_COM; c++) begin
      com_active[c] = (com_lvl_o[2*c +: 2] != LVL_HALF);
      if (com_lvl_o[2*c +: 2] == 2'b11) any_bad = 1'b1;
    end
    for (int s = 0; s < NUM_SEG; s++) begin
      seg_half[s] = (seg_lvl_o[2*s +: 2] == LVL_HALF);
      if (seg_lvl_o[2*s +: 2] == 2'b11) any_bad = 1'b1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (com_lvl_o == '0 && seg_lvl_o == '0));

  assert_no_code3_R2: assert property (@(posedge clk) disable iff (rst)
    run |-> !any_bad);

  assert_one_common_R3: assert property (@(posedge clk) disable iff (rst)
    (com_lvl_o != '0) |-> ($countones(com_active) == 1));

  assert_seg_rail_R6: assert property (@(posedge clk) disable iff (rst)
    (com_lvl_o != '0) |-> (seg_half == '0));

  assert_shadow_frame_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(shadow) |-> (phase == '0));

  assert_backup_low_R8: assert property (@(posedge clk) disable iff (rst)
    backup |=> (com_lvl_o == '0 && seg_lvl_o == '0));
endmodule

// File: tb/lcd_quad_drive_tb_top.sv
module lcd_quad_drive_tb_top;
  localparam int NS  = 4;
  localparam int DIV = 4;
  localparam int W   = 8 + 2 * NS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            backup = 1'b0;
  logic [4*NS-1:0] pat = '0;
  logic [7:0]      com;
  logic [2*NS-1:0] seg;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [W-1:0] expq[$];

  always #2.5 clk = ~clk;

  lcd_quad_drive #(.NUM_SEG(NS), .CLK_HZ(DIV * 600), .FRAME_HZ(75)) dut_i (
    .clk(clk), .rst(rst), .backup(backup), .seg_pat_i(pat),
    .com_lvl_o(com), .seg_lvl_o(seg)
  );

  // Expected output for phase p under pattern pt, from R2/R3/R5/R6
  function automatic logic [W-1:0] expect_vec(int p, logic [4*NS-1:0] pt);
    logic [7:0]      c_v;
    logic [2*NS-1:0] s_v;
    int  k   = p % 4;
    bit  pos = (p < 4);
    for (int i = 0; i < 4; i++)
      c_v[2*i +: 2] = (i == k) ? (pos ? 2'b10 : 2'b00) : 2'b01;
    for (int s = 0; s < NS; s++)
      s_v[2*s +: 2] = pt[4*s + k] ? (pos ? 2'b00 : 2'b10) : (pos ? 2'b10 : 2'b00);
    return {c_v, s_v};
  endfunction

  task automatic push_frame(logic [4*NS-1:0] pt);
    for (int p = 0; p < 8; p++) expq.push_back(expect_vec(p, pt));
  endtask

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: pops an expected item on every output change
  logic [W-1:0] prev = '0;
  int  runlen = 0;
  bit  seen   = 0;
  always @(negedge clk) begin
    logic [W-1:0] cur;
    cur = {com, seg};
    for (int i = 0; i < W / 2; i++)
      if (cur[2*i +: 2] == 2'b11) check(0, "R2 code 11", cur, '0);
    if (cur != prev) begin
      if (cur != '0) begin
        if (seen) check(runlen == DIV, "R4 phase length", W'(runlen), W'(DIV));
        seen = 1;
        if (expq.size() > 0) begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(cur == e, "R3/R5/R6/R7 phase drive", cur, e);
        end
      end else seen = 0;
      runlen = 1;
    end else runlen++;
    prev = cur;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      check(0, "watchdog", '0, '0);
      finish_run();
    end
  end

  initial begin
    pat = 16'h0000;
    repeat (5) @(negedge clk);
    check({com, seg} == '0, "R1 reset low", {com, seg}, '0);
    push_frame(16'h0000);
    push_frame(16'hFFFF);
    push_frame(16'hA5C3);
    rst = 1'b0;
    @(negedge clk);
    check({com, seg} == '0, "R1 first cycle after reset", {com, seg}, '0);
    repeat (11) @(negedge clk);
    pat = 16'hFFFF;                     // mid-frame change, R7
    repeat (32) @(negedge clk);
    pat = 16'hA5C3;
    while (expq.size() != 0) @(negedge clk);
    check(expq.size() == 0, "R7 frames consumed", '0, '0);

    // Backup: outputs low, then restart at phase 0, R8
    backup = 1'b1;
    @(negedge clk);
    check({com, seg} == '0, "R8 backup low", {com, seg}, '0);
    pat = 16'h1E69;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check({com, seg} == '0, "R8 backup held low", {com, seg}, '0);
    end
    push_frame(16'h1E69);
    push_frame(16'h1E69);
    backup = 1'b0;
    @(negedge clk);
    check({com, seg} == '0, "R8 low cycle after release", {com, seg}, '0);
    @(negedge clk);
    check({com, seg} == expect_vec(0, 16'h1E69), "R8 restart phase 0",
          {com, seg}, expect_vec(0, 16'h1E69));
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule